// File: doc/BRIEF.md
# Widening Shift by Element Width

This block takes a 64-bit vector of packed integers and doubles the width of every element, so that each element lands in the upper half of a lane twice its size. The lower half of every lane is filled with zeros. The shift is never an operand: each element always moves left by exactly its own width. A 2-bit size code picks 8-, 16- or 32-bit source elements, which become eight 16-bit, four 32-bit or two 64-bit result lanes. An element keeps its lane index in the result.

A select input chooses zero extension or sign extension of each element before the shift. Because the shift equals the element width, the extension bits are always shifted out. The two choices therefore give identical results. Size code 3 is reserved: for that code the block raises an invalid flag and returns an all-zero vector.

The result is registered. It is captured on a clock edge where the input strobe is high and appears one cycle later with a matching valid flag. While the strobe is low, the result and the invalid flag keep their last values.

Top module: `wsh_widen_shift`

## Requirements
- R1: While the synchronous active-low reset is applied at a clock edge, the following edge leaves out_valid at 0, out_data all zero and out_invalid at 0.
- R2: With in_size = 0, for every byte index i from 0 to 7, out_data[16i+15:16i+8] equals in_src[8i+7:8i] and out_data[16i+7:16i] is zero.
- R3: With in_size = 1, for every halfword index i from 0 to 3, out_data[32i+31:32i+16] equals in_src[16i+15:16i] and out_data[32i+15:32i] is zero.
- R4: With in_size = 2, for every word index i from 0 to 1, out_data[64i+63:64i+32] equals in_src[32i+31:32i] and out_data[64i+31:64i] is zero.
- R5: in_unsigned = 1 (zero extension) and in_unsigned = 0 (sign extension) give the same out_data for every source and size code.
- R6: With in_size = 3, the captured result has out_invalid = 1 and out_data all zero. For in_size 0 to 2, out_invalid is 0.
- R7: out_valid is 1 in exactly the cycle after an edge where in_valid was 1, and 0 after an edge where in_valid was 0. A new input never changes the outputs before the next clock edge.
- R8: After an edge where in_valid was 0, out_data and out_invalid keep the values they had before that edge, whatever the other inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe; inputs are captured on an edge where it is high |
| in_src | input | 64 | Packed source elements |
| in_size | input | 2 | Element size code: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = reserved |
| in_unsigned | input | 1 | 1 selects zero extension, 0 selects sign extension |
| out_valid | output | 1 | High for one cycle after each captured input |
| out_data | output | 128 | Widened and shifted lanes |
| out_invalid | output | 1 | Set when the captured size code was reserved |

## Verification
All of this block's state is the output register, so any internal error shows up at the ports on the first edge after the faulty capture. Possible errors include a wrong lane stride, a swapped size path, extension bits leaking into a lane, or a missed hold. The sweeps cover every size code with both extension choices. They use walking ones, sign-boundary patterns and pseudo-random words. Each source bit therefore has to be seen in its exact result position one cycle later, and each low half has to be seen as zero. Idle cycles with changed inputs show directly whether the register wrongly loads when the strobe is low.

// File: rtl/wsh_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the widening shift block.
// Assumes element widths grow by powers of two from a base width.
package wsh_pkg;
    localparam int unsigned SIZE_W = 2;

    // Element width selected by a size code
    function automatic int unsigned elem_width(int unsigned base_w, int unsigned code);
        return base_w << code;
    endfunction
endpackage

// File: rtl/wsh_size_decode.sv
`timescale 1ns/1ps
// Decodes the size code into a one-hot path select.
// Assumes codes at or above NUM_SIZES are reserved; these give no select and raise reserved.
module wsh_size_decode #(
    parameter int unsigned SIZE_W    = 2,
    parameter int unsigned NUM_SIZES = 3
) (
    input  logic [SIZE_W-1:0]    size_code,
    output logic [NUM_SIZES-1:0] sel,
    output logic                 reserved
);
    // One compare per supported code
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sel
        assign sel[s] = (size_code == SIZE_W'(s));
    end

    // Reserved when no supported code matched
    assign reserved = ~|sel;
endmodule

// File: rtl/wsh_widen_path.sv
`timescale 1ns/1ps
// Widens every ELEM_W-bit element of the source to twice its width and
// shifts it left by ELEM_W, one result lane per source element.
// Assumes SRC_W is a multiple of ELEM_W.
module wsh_widen_path #(
    parameter int unsigned SRC_W  = 64,
    parameter int unsigned ELEM_W = 8
) (
    input  logic [SRC_W-1:0]   src,
    input  logic               is_unsigned,
    output logic [2*SRC_W-1:0] wide
);
    localparam int unsigned LANES  = SRC_W / ELEM_W;
    localparam int unsigned LANE_W = 2 * ELEM_W;

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [ELEM_W-1:0] elem;
        logic [LANE_W-1:0] ext;
        // Pick the element out of the source
        assign elem = src[lane*ELEM_W +: ELEM_W];
        // Sign or zero extension to the double width
        assign ext  = {{ELEM_W{~is_unsigned & elem[ELEM_W-1]}}, elem};
        // Shift by the element width into the upper half of the lane
        assign wide[lane*LANE_W +: LANE_W] = ext << ELEM_W;
    end
endmodule

// File: rtl/wsh_widen_shift.sv
`timescale 1ns/1ps
// Widening shift by element width, with a one-cycle registered result.
// Builds one widening path per supported size and muxes the result by the size code.
// A reserved code gives zero data and sets the invalid flag.
// Assumes a synchronous active-low reset; the register loads only on edges with in_valid high.
module wsh_widen_shift
    import wsh_pkg::*;
#(
    parameter int unsigned SRC_W     = 64,
    parameter int unsigned BASE_W    = 8,
    parameter int unsigned NUM_SIZES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SRC_W-1:0]     in_src,
    input  logic [SIZE_W-1:0]    in_size,
    input  logic                 in_unsigned,
    output logic                 out_valid,
    output logic [2*SRC_W-1:0]   out_data,
    output logic                 out_invalid
);
    localparam int unsigned DST_W = 2 * SRC_W;

    logic [NUM_SIZES-1:0] sel;
    logic                 reserved;
    logic [DST_W-1:0]     path [NUM_SIZES];
    logic [DST_W-1:0]     picked;

    wsh_size_decode #(
        .SIZE_W    (SIZE_W),
        .NUM_SIZES (NUM_SIZES)
    ) u_decode (
        .size_code (in_size),
        .sel       (sel),
        .reserved  (reserved)
    );

    // One widening path per element size
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_path
        wsh_widen_path #(
            .SRC_W  (SRC_W),
            .ELEM_W (elem_width(BASE_W, s))
        ) u_path (
            .src         (in_src),
            .is_unsigned (in_unsigned),
            .wide        (path[s])
        );
    end

    // OR-mux of the selected path; zero when the code is reserved
    always_comb begin
        picked = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (sel[s]) picked = picked | path[s];
        end
    end

    // Output register: loads on a strobe, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= picked;
                out_invalid <= reserved;
            end
        end
    end
endmodule

// File: rtl/wsh_widen_shift_chk.sv
`timescale 1ns/1ps
// Property checker for wsh_widen_shift, relating captured inputs to the
// registered outputs one edge later. Bound to every instance of the top.
module wsh_widen_shift_chk
    import wsh_pkg::*;
#(
    parameter int unsigned SRC_W     = 64,
    parameter int unsigned BASE_W    = 8,
    parameter int unsigned NUM_SIZES = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [SRC_W-1:0]   in_src,
    input logic [SIZE_W-1:0]  in_size,
    input logic               out_valid,
    input logic [2*SRC_W-1:0] out_data,
    input logic               out_invalid
);
    localparam int unsigned DST_W = 2 * SRC_W;

    // Mask of the lower half of every lane for element width ew
    function automatic logic [DST_W-1:0] low_mask(int unsigned ew);
        logic [DST_W-1:0] m;
        for (int b = 0; b < DST_W; b++) m[b] = ((b % (2 * ew)) < ew);
        return m;
    endfunction

    // Gathers the upper halves of all lanes back into a packed source word
    function automatic logic [SRC_W-1:0] upper_halves(logic [DST_W-1:0] d, int unsigned ew);
        logic [SRC_W-1:0] r;
        for (int b = 0; b < SRC_W; b++) r[b] = d[(b / ew) * 2 * ew + ew + (b % ew)];
        return r;
    endfunction

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && !out_invalid));

    assert_byte_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == SIZE_W'(0)) |=>
        ((out_data & low_mask(BASE_W)) == '0 && upper_halves(out_data, BASE_W) == $past(in_src)));

    assert_half_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == SIZE_W'(1)) |=>
        ((out_data & low_mask(BASE_W * 2)) == '0 && upper_halves(out_data, BASE_W * 2) == $past(in_src)));

    assert_word_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == SIZE_W'(2)) |=>
        ((out_data & low_mask(BASE_W * 4)) == '0 && upper_halves(out_data, BASE_W * 4) == $past(in_src)));

    assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size >= SIZE_W'(NUM_SIZES)) |=> (out_invalid && out_data == '0));

    assert_supported_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size < SIZE_W'(NUM_SIZES)) |=> !out_invalid);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_invalid)));
endmodule

bind wsh_widen_shift wsh_widen_shift_chk #(
    .SRC_W     (SRC_W),
    .BASE_W    (BASE_W),
    .NUM_SIZES (NUM_SIZES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_src      (in_src),
    .in_size     (in_size),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_invalid (out_invalid)
);

// File: tb/wsh_widen_shift_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every size code and extension choice over
// walking-one, boundary and pseudo-random sources; expected lanes are computed
// arithmetically as element times 2**width.
module wsh_widen_shift_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  in_src = '0;
    logic [1:0]   in_size = '0;
    logic         in_unsigned = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_invalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    wsh_widen_shift u_wsh_widen_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_src      (in_src),
        .in_size     (in_size),
        .in_unsigned (in_unsigned),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_invalid (out_invalid)
    );

    function automatic logic [127:0] model(logic [63:0] src, int sz, bit uns);
        logic [127:0] r;
        logic [127:0] e;
        int ew;
        r = '0;
        if (sz > 2) return r;
        ew = 8 << sz;
        for (int i = 0; i < 64 / ew; i++) begin
            e = '0;
            for (int b = 0; b < ew; b++) e[b] = src[i*ew + b];
            if (!uns && src[i*ew + ew - 1]) e = e - (128'd1 << ew);
            e = e * (128'd1 << ew);
            for (int b = 0; b < 2 * ew; b++) r[i*2*ew + b] = e[b];
        end
        return r;
    endfunction

    task automatic check128(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Applies one strobed input and checks the result one edge later
    task automatic apply(logic [63:0] src, int sz, bit uns);
        string tag;
        tag = (sz == 0) ? "R2" : (sz == 1) ? "R3" : (sz == 2) ? "R4" : "R6";
        in_valid = 1'b1; in_src = src; in_size = 2'(sz); in_unsigned = uns;
        @(negedge clk);
        check128(tag, out_data, model(src, sz, uns));
        check1(tag, out_invalid, sz == 3);
        check1("R7", out_valid, 1'b1);
    endtask

    // Runs both extension choices and checks they agree (R5)
    task automatic apply_pair(logic [63:0] src, int sz);
        logic [127:0] signed_res;
        apply(src, sz, 1'b0);
        signed_res = out_data;
        apply(src, sz, 1'b1);
        check128("R5", out_data, signed_res);
    endtask

    initial begin
        logic [127:0] held;
        logic         held_inv;
        // R1: reset dominates a strobe
        in_valid = 1'b1; in_src = '1; in_size = 2'd3;
        repeat (3) @(negedge clk);
        check1("R1", out_valid, 1'b0);
        check128("R1", out_data, '0);
        check1("R1", out_invalid, 1'b0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        // R7: no change before the edge
        in_valid = 1'b1; in_src = 64'h8001_7FFF_FF00_0080; in_size = 2'd0; in_unsigned = 1'b0;
        #1;
        check1("R7", out_valid, 1'b0);
        check128("R7", out_data, '0);
        @(negedge clk);
        check1("R7", out_valid, 1'b1);
        check128("R2", out_data, model(64'h8001_7FFF_FF00_0080, 0, 1'b0));

        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 64; k++) apply_pair(64'd1 << k, sz);
            apply_pair('0, sz);
            apply_pair('1, sz);
            apply_pair(64'h8080_8080_8080_8080, sz);
            apply_pair(64'h7F7F_7F7F_7F7F_7F7F, sz);
            apply_pair(64'h8000_8000_8000_8000, sz);
            apply_pair(64'h8000_0000_7FFF_FFFF, sz);
            apply_pair(64'hAAAA_5555_CCCC_3333, sz);
            for (int k = 0; k < 120; k++) begin
                rng = rng ^ (rng << 13);
                rng = rng ^ (rng >> 7);
                rng = rng ^ (rng << 17);
                apply_pair(rng, sz);
            end
        end

        // R8: idle cycles with changed inputs hold the last result
        apply(64'h0123_4567_89AB_CDEF, 3, 1'b0);
        apply(64'h0123_4567_89AB_CDEF, 1, 1'b1);
        held = out_data; held_inv = out_invalid;
        in_valid = 1'b0; in_src = 64'hFEDC_BA98_7654_3210; in_size = 2'd3;
        @(negedge clk);
        check1("R7", out_valid, 1'b0);
        check128("R8", out_data, held);
        check1("R8", out_invalid, held_inv);
        in_size = 2'd2; in_unsigned = 1'b0;
        @(negedge clk);
        check128("R8", out_data, held);
        check1("R8", out_invalid, held_inv);

        // R6 flag then cleared by a valid code
        apply(64'h1111_2222_3333_4444, 3, 1'b1);
        held_inv = out_invalid;
        in_valid = 1'b0; in_size = 2'd0;
        @(negedge clk);
        check1("R8", out_invalid, held_inv);
        apply(64'h1111_2222_3333_4444, 2, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule